// File: doc/BRIEF.md
# Answer-Window Countdown Timer

This block times the answering window of a buzzer-based quiz system. It holds a packed BCD count, two decimal digits by default, and loads the round length (20 seconds by default) on reset or on a host clear. It steps down by one on each one-cycle second tick. It counts only while the host has opened the window and no station has been captured as the winner.

A capture freezes the count so that the display keeps the time that was left. When the count reaches 00 the block stops there and raises a timeout flag. That flag drives the alarm and stays set until the host clears the block for the next round. The second tick and the display decoding come from neighbouring blocks, and everything runs in one system clock domain.

Top module: `answer_timer`

## Requirements
- R1: While rst_n is low at a clock edge, or clear is high, the count loads the start value (tens digit 2 in bits [7:4], units digit 0 in bits [3:0]) and timeout goes low on that edge.
- R2: On an edge where tick is high, window_open is high, captured is low and timeout is low, the count drops by exactly one second.
- R3: When the units digit is 0 and the count is not 00, a decrement sets units to 9 and lowers tens by one.
- R4: Without a tick the count does not change.
- R5: While window_open is low the count holds its value and timeout does not rise.
- R6: While captured is high the count is frozen, whatever tick does.
- R7: The decrement that makes the count 00 sets timeout on the same edge, and the count never goes below 00.
- R8: Once set, timeout stays high and the count stays 00 until clear. Clear then restarts a full round from the start value.
- R9: Every digit of the count is always a valid BCD value (0 to 9).
- R10: Clear takes priority over a tick that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Host clear: reload the start value and drop the alarm |
| tick | input | 1 | One-cycle pulse, once per second |
| window_open | input | 1 | High while the host allows answers |
| captured | input | 1 | High once a winning station is held |
| bcd_count | output | 8 | Remaining seconds as packed BCD, tens in the upper nibble |
| timeout | output | 1 | Latched alarm: the window ran out with nobody buzzing in |

## Verification
The count is driven with several patterns:
- Sparse ticks in an open window show single-step decrements and the decade borrow from 20 to 19 and from 10 to 09.
- Ticks with the window closed or a capture held separate a true freeze from a count that is merely slow.
- A dense tick run goes through 01 to 00 and shows whether timeout rises on that exact edge and whether the count then sticks at 00.
- Clear pulses that coincide with ticks, followed by a long pseudo-random mix of all inputs, test clear priority and any interactions the directed steps miss.

// File: rtl/answer_timer_pkg.sv
// Shared widths and types for the answer-window countdown timer.
// Assumes decimal digits are stored as 4-bit BCD.
package answer_timer_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;
    localparam bcd_t BCD_NINE = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;
    localparam bcd_t BCD_ONE  = 4'd1;
endpackage

// File: rtl/bcd_down_digit.sv
// One decade of a BCD down-counter.
// Decrements when dec_in is high and wraps 0 to 9 while raising borrow_out.
// Assumes the load value is valid BCD and load overrides dec_in.
module bcd_down_digit
    import answer_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  bcd_t load_val,
    input  logic dec_in,
    output bcd_t q,
    output logic is_zero,
    output logic is_one,
    output logic borrow_out
);
    bcd_t q_r;

    // Hold, load or step this digit.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q_r <= load_val;
        end else if (dec_in) begin
            q_r <= (q_r == BCD_ZERO) ? BCD_NINE : bcd_t'(q_r - 1'b1);
        end
    end

    // Flags for the neighbouring digits and the controller.
    always_comb begin
        is_zero    = (q_r == BCD_ZERO);
        is_one     = (q_r == BCD_ONE);
        borrow_out = dec_in && is_zero;
    end

    assign q = q_r;

    AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        q_r <= BCD_NINE);  // R9
    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec_in && is_zero) |=> (q_r == BCD_NINE));  // R3
endmodule

// File: rtl/timeout_ctrl.sv
// Run and alarm control for the countdown.
// Produces the one-cycle step enable and the latched timeout flag.
// Assumes at_zero and ends_next are taken from the current count.
module timeout_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic window_open,
    input  logic captured,
    input  logic at_zero,
    input  logic ends_next,
    output logic step,
    output logic timeout
);
    logic active;
    logic timeout_r;

    // Decide whether this cycle counts and whether it hits zero.
    always_comb begin
        active = tick && window_open && !captured && !timeout_r && !clear;
        step   = active && !at_zero;
    end

    // Set the alarm on the edge that reaches zero; only clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            timeout_r <= 1'b0;
        end else if (active && (at_zero || ends_next)) begin
            timeout_r <= 1'b1;
        end
    end

    assign timeout = timeout_r;

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_r && !clear) |=> timeout_r);  // R8
    AST_ALARM_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_r && !window_open) |=> !timeout_r);  // R5
    AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !timeout_r);  // R10
endmodule

// File: rtl/answer_timer.sv
// Answer-window countdown: a BCD down-counter of NUM_DIG digits.
// Loads START_BCD on reset or clear and steps on each enabled tick.
// Stops at zero with a latched timeout flag.
// Assumes tick is a single-cycle pulse in the clk domain.
module answer_timer
    import answer_timer_pkg::*;
#(
    parameter int NUM_DIG = 2,
    parameter logic [NUM_DIG*DIGIT_W-1:0] START_BCD = 8'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       tick,
    input  logic                       window_open,
    input  logic                       captured,
    output logic [NUM_DIG*DIGIT_W-1:0] bcd_count,
    output logic                       timeout
);
    localparam int CNT_W = NUM_DIG * DIGIT_W;

    logic [NUM_DIG-1:0] zero_v;
    logic [NUM_DIG-1:0] one_v;
    logic [NUM_DIG-1:0] borrow_v;
    logic [NUM_DIG-1:0] dec_v;
    logic               step;
    logic               at_zero;
    logic               ends_next;
    logic               upper_zero;

    // Chain the digits: each one steps on the borrow of the digit below.
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_digit
        if (g == 0) begin : g_low
            assign dec_v[g] = step;
        end else begin : g_up
            assign dec_v[g] = borrow_v[g-1];
        end
        bcd_down_digit u_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (clear),
            .load_val   (START_BCD[g*DIGIT_W +: DIGIT_W]),
            .dec_in     (dec_v[g]),
            .q          (bcd_count[g*DIGIT_W +: DIGIT_W]),
            .is_zero    (zero_v[g]),
            .is_one     (one_v[g]),
            .borrow_out (borrow_v[g])
        );
    end

    // Find out whether the count is zero or one step from zero.
    always_comb begin
        upper_zero = 1'b1;
        for (int i = 1; i < NUM_DIG; i++) begin
            upper_zero = upper_zero && zero_v[i];
        end
        at_zero   = &zero_v;
        ends_next = one_v[0] && upper_zero;
    end

    timeout_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .tick        (tick),
        .window_open (window_open),
        .captured    (captured),
        .at_zero     (at_zero),
        .ends_next   (ends_next),
        .step        (step),
        .timeout     (timeout)
    );

    AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bcd_count == START_BCD));  // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(bcd_count));  // R4
    AST_HOLD_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && captured) |=> $stable(bcd_count));  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (bcd_count == CNT_W'(0)));  // R7
endmodule

// File: tb/answer_timer_tb_top.sv
// Bench: behavioural seconds model compared with the DUT on every clock.
module answer_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int START_SEC  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       tick = 1'b0;
    logic       window_open = 1'b0;
    logic       captured = 1'b0;
    logic [7:0] bcd_count;
    logic       timeout;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    int    ref_sec = START_SEC;
    bit    ref_to = 1'b0;
    string tag = "R1";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    answer_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .tick        (tick),
        .window_open (window_open),
        .captured    (captured),
        .bcd_count   (bcd_count),
        .timeout     (timeout)
    );

    // Reference model on whole seconds.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || clear) begin
            ref_sec = START_SEC;
            ref_to  = 1'b0;
        end else if (tick && window_open && !captured && !ref_to) begin
            if (ref_sec == 0) begin
                ref_to = 1'b1;
            end else begin
                ref_sec--;
                if (ref_sec == 0) ref_to = 1'b1;
            end
        end
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (bcd_count[7:4] !== 4'(ref_sec / 10) ||
                bcd_count[3:0] !== 4'(ref_sec % 10) ||
                timeout !== ref_to) begin
                failures++;
                $display("FAIL %s: count=%h timeout=%b expected count=%0d%0d timeout=%b",
                         tag, bcd_count, timeout, ref_sec / 10, ref_sec % 10, ref_to);
            end
            checks++;
            if (bcd_count[7:4] > 4'd9 || bcd_count[3:0] > 4'd9) begin
                failures++;
                $display("FAIL R9: count=%h expected digits 0..9", bcd_count);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected end before 20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            wait_cycles(gap);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        tag = "R1";
        wait_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(2);
        tag = "R4";
        window_open = 1'b1;
        wait_cycles(6);
        tag = "R3";                    // 20 -> 19 borrows
        pulse_ticks(1, 1);
        tag = "R2";
        pulse_ticks(8, 2);             // down to 11
        tag = "R3";                    // 11 -> 10 -> 09
        pulse_ticks(2, 0);
        tag = "R6";
        captured = 1'b1;
        pulse_ticks(5, 0);
        captured = 1'b0;
        tag = "R5";
        window_open = 1'b0;
        pulse_ticks(5, 1);
        tag = "R10";                   // clear together with a tick
        window_open = 1'b1;
        @(negedge clk) begin clear = 1'b1; tick = 1'b1; end
        @(negedge clk) begin clear = 1'b0; tick = 1'b0; end
        wait_cycles(1);
        tag = "R7";
        @(negedge clk) tick = 1'b1;
        wait_cycles(24);               // reaches 00, then ticks keep coming
        tag = "R8";
        wait_cycles(5);
        window_open = 1'b0;
        wait_cycles(3);
        @(negedge clk) begin tick = 1'b0; clear = 1'b1; end
        @(negedge clk) clear = 1'b0;
        window_open = 1'b1;
        pulse_ticks(3, 0);
        tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        tag = "R2";                    // pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick        = lfsr[0];
            window_open = lfsr[3] | lfsr[5];
            captured    = (lfsr[7:6] == 2'b11);
            clear       = (lfsr[15:11] == 5'd0);
        end
        @(negedge clk) begin tick = 1'b0; clear = 1'b0; end
        wait_cycles(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule